// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Line-Break Generation

This block serialises 8-bit characters onto a single transmit line. A one-character holding register accepts a write from the host; on a baud tick the character moves into a shift register and is sent as one low start bit, eight data bits with the least significant bit first, and one high stop bit. Each bit lasts one baud tick period. The bench supplies the baud tick, which is a single-cycle pulse.

A break request forces the line low for as long as the request stays set. Characters that are already queued take precedence. The break begins only after the shift register and the holding register have both emptied. A character written while the break is in progress stays in the holding register. Once the request is withdrawn, the line is driven high for one full bit period and then that character is sent. A write to a full holding register is discarded and raises a sticky collision flag.

Top module: `uart_brk_tx`

## Requirements
- R1: After reset, `txd` is high, `hold_empty` is high and `wr_collide` is low. With no character queued and no break requested, `txd` stays high.
- R2: A frame is a low start bit, then bits 0 to 7 of the character in that order, then a high stop bit. Each bit lasts exactly one baud tick period, and `txd` changes only in the cycle after a `baud_tick` pulse.
- R3: Once a break has begun, `txd` is held low continuously. The break ends at the first baud tick at which `brk_req` is low.
- R4: When `brk_req` is set, the character in the shift register and any character in the holding register are sent in full before `txd` goes low for the break.
- R5: `hold_empty` falls in the cycle after an accepted write. It rises in the cycle after the baud tick that moves the character into the shift register.
- R6: A character written during a break is not sent while the break lasts, and `hold_empty` stays low for that whole time.
- R7: After a break ends, `txd` is high for one full bit period. The held character's start bit then begins at the next baud tick.
- R8: A write while `hold_empty` is low leaves the held character unchanged and sets `wr_collide`. `wr_collide` stays set until reset.
- R9: If a character is waiting when a stop bit ends, its start bit begins at that same baud tick, with no idle bit between the two frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to queue |
| brk_req | input | 1 | Break request; holds the line low while set |
| baud_tick | input | 1 | One-cycle pulse marking each bit boundary |
| txd | output | 1 | Serial transmit line |
| hold_empty | output | 1 | High when the holding register can accept a character |
| wr_collide | output | 1 | Sticky flag for a write to a full holding register |

## Verification
Every result is registered once. `txd` follows the state that a baud tick updates, so it changes in the cycle after that tick. `hold_empty` and `wr_collide` change in the cycle after the write or the transfer that causes them. The bench drives its inputs on the falling edge and advances a queue-based model at each rising edge, using the same sampled inputs. It then compares all three outputs at the next falling edge, so each expected value is checked exactly one register stage after its cause. Each comparison is tagged with the requirement that belongs to the model's current phase: idle, frame, break or post-break mark.

// File: rtl/uart_brk_pkg.sv
package uart_brk_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_SEND  = 2'd1,
    MODE_BREAK = 2'd2,
    MODE_MARK  = 2'd3
  } tx_mode_e;
endpackage

// File: rtl/utx_hold.sv
module utx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  output logic              hold_full,
  output logic [DATA_W-1:0] hold_data,
  output logic              collide
);
  logic              full_n;
  logic [DATA_W-1:0] data_n;
  logic              collide_n;

  always_comb begin
    full_n    = hold_full;
    data_n    = hold_data;
    collide_n = collide;
    if (load) full_n = 1'b0;
    if (wr_en) begin
      if (hold_full) collide_n = 1'b1;
      else begin
        full_n = 1'b1;
        data_n = wr_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
      collide   <= 1'b0;
    end else begin
      hold_full <= full_n;
      hold_data <= data_n;
      collide   <= collide_n;
    end
  end

  // R8
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hold_full) |=> $stable(hold_data));
  // R8
  collide_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(collide));
  // R5
  load_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !hold_full);
endmodule

// File: rtl/utx_shift.sv
module utx_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [DATA_W-1:0] data,
  output logic              line_bit,
  output logic              last
);
  localparam int FRAME_BITS = DATA_W + 2;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  logic [FRAME_BITS-1:0] sreg, sreg_n;
  logic [CNT_W-1:0]      cnt, cnt_n;

  always_comb begin
    sreg_n = sreg;
    cnt_n  = cnt;
    if (load) begin
      sreg_n = {1'b1, data, 1'b0};
      cnt_n  = '0;
    end else if (advance) begin
      sreg_n = {1'b1, sreg[FRAME_BITS-1:1]};
      cnt_n  = cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg <= '1;
      cnt  <= '0;
    end else begin
      sreg <= sreg_n;
      cnt  <= cnt_n;
    end
  end

  assign line_bit = sreg[0];
  assign last     = (cnt == LAST_IDX);

  // R2
  frame_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !line_bit);
  // R2
  stop_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> line_bit);
endmodule

// File: rtl/utx_ctrl.sv
module utx_ctrl
  import uart_brk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  logic     brk_req,
  input  logic     hold_full,
  input  logic     last,
  output logic     load,
  output logic     advance,
  output tx_mode_e mode
);
  tx_mode_e mode_n;
  logic     frame_end;
  logic     may_load;

  assign frame_end = (mode == MODE_SEND) && last;
  assign may_load  = (mode == MODE_IDLE) || (mode == MODE_MARK) || frame_end;
  assign load      = tick && hold_full && may_load;
  assign advance   = tick && (mode == MODE_SEND) && !last;

  always_comb begin
    mode_n = mode;
    if (tick) begin
      unique case (mode)
        MODE_BREAK: if (!brk_req) mode_n = MODE_MARK;
        MODE_SEND: begin
          if (last) begin
            if (hold_full)    mode_n = MODE_SEND;
            else if (brk_req) mode_n = MODE_BREAK;
            else              mode_n = MODE_IDLE;
          end
        end
        default: begin
          if (hold_full)    mode_n = MODE_SEND;
          else if (brk_req) mode_n = MODE_BREAK;
          else              mode_n = MODE_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= MODE_IDLE;
    else        mode <= mode_n;
  end
endmodule

// File: rtl/uart_brk_tx.sv
module uart_brk_tx
  import uart_brk_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              brk_req,
  input  logic              baud_tick,
  output logic              txd,
  output logic              hold_empty,
  output logic              wr_collide
);
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              load;
  logic              advance;
  logic              line_bit;
  logic              last;
  tx_mode_e          mode;
  logic              in_brk;

  utx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .load(load), .hold_full(hold_full), .hold_data(hold_data),
    .collide(wr_collide)
  );

  utx_shift #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
    .data(hold_data), .line_bit(line_bit), .last(last)
  );

  utx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .tick(baud_tick), .brk_req(brk_req),
    .hold_full(hold_full), .last(last), .load(load), .advance(advance),
    .mode(mode)
  );

  assign in_brk     = (mode == MODE_BREAK);
  assign hold_empty = !hold_full;

  always_comb begin
    unique case (mode)
      MODE_SEND:  txd = line_bit;
      MODE_BREAK: txd = 1'b0;
      default:    txd = 1'b1;
    endcase
  end

  // R2
  txd_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !baud_tick |=> $stable(txd));
  // R6
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_brk && hold_full) |=> hold_full);
  // R4
  brk_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_brk) |-> !$past(hold_full));
  // R3
  brk_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_brk && brk_req) |=> in_brk);
endmodule

// File: tb/uart_brk_tx_test.sv
module uart_brk_tx_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       brk_req;
  logic       baud_tick;
  logic       txd;
  logic       hold_empty;
  logic       wr_collide;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  uart_brk_tx uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .brk_req(brk_req), .baud_tick(baud_tick), .txd(txd),
    .hold_empty(hold_empty), .wr_collide(wr_collide)
  );

  // baud tick: one pulse every 4 cycles
  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    baud_tick = (tdiv == 3);
  end

  // behavioural model: 0 idle, 1 frame, 2 break, 3 mark after break
  int  m_mode = 0;
  bit  m_full = 0;
  bit  m_coll = 0;
  int  m_data = 0;
  bit  m_bits[$];

  function automatic void start_frame(int d);
    m_bits.delete();
    m_bits.push_back(1'b0);
    for (int i = 0; i < 8; i++) m_bits.push_back(d[i]);
    m_bits.push_back(1'b1);
    m_mode = 1;
  endfunction

  function automatic void pick_next();
    if (m_full) begin start_frame(m_data); m_full = 0; end
    else if (brk_req) m_mode = 2;
    else m_mode = 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_full = 0; m_coll = 0; m_bits.delete();
    end else begin
      bit old_full;
      old_full = m_full;
      if (baud_tick) begin
        case (m_mode)
          1: if (m_bits.size() > 1) void'(m_bits.pop_front()); else pick_next();
          2: if (!brk_req) m_mode = 3;
          default: pick_next();
        endcase
      end
      if (wr_en) begin
        if (old_full) m_coll = 1;
        else begin m_full = 1; m_data = wr_data; end
      end
    end
  end

  function automatic bit exp_txd();
    if (m_mode == 1) return m_bits[0];
    if (m_mode == 2) return 1'b0;
    return 1'b1;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n === 1'b1 && !finished) begin
      string rq;
      case (m_mode)
        1: rq = "R2";
        2: rq = "R3";
        3: rq = "R7";
        default: rq = "R1";
      endcase
      check(rq, "txd", int'(txd), int'(exp_txd()));
      check(m_mode == 2 ? "R6" : "R5", "hold_empty", int'(hold_empty), int'(!m_full));
      check("R8", "wr_collide", int'(wr_collide), int'(m_coll));
    end
  end

  task automatic write(input logic [7:0] d);
    @(negedge clk); #0.1;
    wr_en = 1'b1; wr_data = d;
    @(negedge clk); #0.1;
    wr_en = 1'b0;
  endtask

  task automatic wait_ticks(int n);
    for (int i = 0; i < n * 4; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; brk_req = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "txd reset", int'(txd), 1);
    check("R1", "hold_empty reset", int'(hold_empty), 1);
    check("R1", "wr_collide reset", int'(wr_collide), 0);
    rst_n = 1'b1;
    wait_ticks(3);
    // R2/R9 back-to-back frames
    write(8'hA5);
    wait_ticks(2);
    write(8'h3C);
    wait_ticks(24);
    // R4 break requested while a frame runs and another waits
    write(8'h0F);
    wait_ticks(1);
    write(8'hF0);
    brk_req = 1'b1;
    wait_ticks(30);
    // R6 write during break, then R8 collision
    write(8'h81);
    write(8'h55);
    wait_ticks(10);
    check("R6", "txd low during break", int'(txd), 0);
    check("R6", "hold_empty during break", int'(hold_empty), 0);
    // R7 release break
    brk_req = 1'b0;
    wait_ticks(16);
    check("R8", "collision sticky", int'(wr_collide), 1);
    // R3 break from idle, short
    brk_req = 1'b1;
    wait_ticks(5);
    brk_req = 1'b0;
    wait_ticks(4);
    check("R1", "idle high", int'(txd), 1);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end
endmodule